// File: doc/BRIEF.md
# SRAM Chip-Select Bus Cycle Generator

This block turns single requests from an internal master into external bus cycles for one chip-select area populated with byte-lane SRAM. The requester presents an address, a direction flag, byte enables and write data. It then gets back a one-tick completion pulse and, for reads, the sampled data word. On the bus side the block drives an active-low chip select, the address, a read strobe, one write-enable strobe per byte lane, a read/write direction line, and the write data with its output enable.

All timing runs from a half-cycle tick clock, `clk`, which runs at twice the bus rate, so one tick is half a bus cycle. A 32-bit control register holds a 2-bit setup field in bits 12:11 and a strobe-scheme bit in bit 20. The setup field sets the distance from chip-select and address assertion to strobe assertion: 1, 3, 5 or 7 ticks (0.5, 1.5, 2.5 or 3.5 cycles). The strobe-scheme bit picks one of two schemes. With the bit at 0, the byte-lane strobes pulse like a read strobe and the direction line covers the whole write cycle. With the bit at 1, the byte-lane strobes cover the whole cycle and the direction line pulses only in the write window. The strobe window lasts `STROBE_HC` ticks. Chip select and address are held for one tick after the strobes release.

Top module: `sramcs_bus_gen`

## Requirements
- R1: After reset the register reads 0x00000500, `req_ready` is 1, `rsp_done` is 0, and `bus_cs_n`, `bus_rd_n`, `bus_rdwr_n` and every `bus_we_n` lane are 1.
- R2: A register write stores only bit 20 and bits 12:0. Bits 31:21 and 19:13 always read as 0, whatever value was written.
- R3: The first strobe tick comes 2*S+1 ticks after the first tick of `bus_cs_n` low, where S is register bits 12:11.
- R4: The strobe window lasts `STROBE_HC` ticks. `bus_cs_n` stays low for exactly one tick after it. `bus_addr` holds the request address on every tick while `bus_cs_n` is low.
- R5: `bus_rd_n` is low only during the strobe window of a read cycle and never during a write cycle.
- R6: With bit 20 at 0, lane i of `bus_we_n` is low exactly in the strobe window when byte enable bit i is 1, for reads and for writes. `bus_rdwr_n` is low for the whole chip-select-low time of a write and stays high in reads.
- R7: With bit 20 at 1, lane i of `bus_we_n` is low for the whole chip-select-low time when byte enable bit i is 1. `bus_rdwr_n` is low only in the strobe window of a write.
- R8: The read data is captured on the edge that ends the strobe window. `rsp_done` is high for exactly the one tick that follows (the hold tick), and `rsp_rdata` then carries the captured word.
- R9: A request is taken only on an edge where `req_ready` is 1. `req_ready` is 1 only while no cycle is in progress. A `req_valid` raised during a cycle changes nothing on the bus.
- R10: A cycle uses the register value that was in force on its accept edge. A register write on that same edge, or any later one within the cycle, applies from the next request on.
- R11: During a write, `bus_doe` is 1 and `bus_dout` equals the write data for the whole chip-select-low time. During a read, `bus_doe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle tick clock (twice the bus rate) |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write value |
| reg_rdata | output | 32 | Control register read value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | ADDR_W | Request address |
| req_be | input | LANES | Byte enables, bit i for lane i |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-tick completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | LANES | Byte-lane write-enable strobes, active low |
| bus_rdwr_n | output | 1 | Direction line, low marks write |
| bus_dout | output | DATA_W | Write data to the bus |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | DATA_W | Read data from the bus |

## Verification
Two events can meet on one edge: a control register write and the acceptance of a new request. The same collision is possible with a register write that lands in the middle of a running cycle. The bench provokes both. It raises `reg_wr` with a new setup field and strobe scheme on exactly the tick where `req_valid` meets an idle block, and on randomly chosen ticks inside the setup phase. It judges the result by comparing every tick of the running cycle against the old timing, then the next cycle against the new timing, and by reading the register back after each cycle.

// File: rtl/sramcs_pkg.sv
`timescale 1ns/1ps
package sramcs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } bus_st_e;

  typedef struct packed {
    logic       bas;   // strobe scheme: 1 = lanes span whole cycle
    logic [1:0] sw;    // setup field, delay = 2*sw+1 ticks
  } tim_cfg_t;

  localparam int          CFG_W        = 32;
  localparam int          SCHEME_BIT   = 20;
  localparam int          SETUP_LSB    = 11;
  localparam logic [31:0] CFG_RESET    = 32'h0000_0500;
  localparam logic [31:0] CFG_WR_MASK  = 32'h0010_1FFF;

endpackage

// File: rtl/sramcs_rst_sync.sv
`timescale 1ns/1ps
module sramcs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/sramcs_cfg.sv
`timescale 1ns/1ps
module sramcs_cfg
  import sramcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output tim_cfg_t         tcfg
);
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wdata & CFG_WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign rdata    = cfg_q;
  assign tcfg.bas = cfg_q[SCHEME_BIT];
  assign tcfg.sw  = cfg_q[SETUP_LSB +: 2];

  // R2: a write lands masked on the next edge
  p_write_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata == ($past(wdata) & CFG_WR_MASK)));
endmodule

// File: rtl/sramcs_seq.sv
`timescale 1ns/1ps
module sramcs_seq
  import sramcs_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int LANES     = DATA_W / 8,
  parameter int STROBE_HC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tim_cfg_t          tcfg,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic [DATA_W-1:0] bus_din,
  output bus_st_e           st_nxt,
  output logic              cyc_write_nxt,
  output logic              cyc_bas_nxt,
  output logic [ADDR_W-1:0] cyc_addr_nxt,
  output logic [LANES-1:0]  cyc_be_nxt,
  output logic [DATA_W-1:0] cyc_wdata_nxt,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int MAX_CNT = (STROBE_HC > 7) ? STROBE_HC : 7;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  bus_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              load, sample;
  logic              cyc_write_q, cyc_bas_q;
  logic [ADDR_W-1:0] cyc_addr_q;
  logic [LANES-1:0]  cyc_be_q;
  logic [DATA_W-1:0] cyc_wdata_q;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  assign req_ready = (st_q == ST_IDLE);

  // next-state process
  always_comb begin
    st_nxt  = st_q;
    cnt_nxt = cnt_q;
    load    = 1'b0;
    sample  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          load    = 1'b1;
          st_nxt  = ST_SETUP;
          cnt_nxt = CNT_W'({tcfg.sw, 1'b0});
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          st_nxt  = ST_STROBE;
          cnt_nxt = CNT_W'(STROBE_HC - 1);
        end else begin
          cnt_nxt = cnt_q - CNT_W'(1);
        end
      end
      ST_STROBE: begin
        if (cnt_q == '0) begin
          st_nxt = ST_HOLD;
          sample = 1'b1;
        end else begin
          cnt_nxt = cnt_q - CNT_W'(1);
        end
      end
      ST_HOLD: st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign cyc_write_nxt = load ? req_write : cyc_write_q;
  assign cyc_bas_nxt   = load ? tcfg.bas  : cyc_bas_q;
  assign cyc_addr_nxt  = load ? req_addr  : cyc_addr_q;
  assign cyc_be_nxt    = load ? req_be    : cyc_be_q;
  assign cyc_wdata_nxt = load ? req_wdata : cyc_wdata_q;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      cyc_write_q <= 1'b0;
      cyc_bas_q   <= 1'b0;
      cyc_addr_q  <= '0;
      cyc_be_q    <= '0;
      cyc_wdata_q <= '0;
      done_q      <= 1'b0;
      rdata_q     <= '0;
    end else begin
      st_q   <= st_nxt;
      cnt_q  <= cnt_nxt;
      done_q <= sample;
      if (load) begin
        cyc_write_q <= req_write;
        cyc_bas_q   <= tcfg.bas;
        cyc_addr_q  <= req_addr;
        cyc_be_q    <= req_be;
        cyc_wdata_q <= req_wdata;
      end
      if (sample && !cyc_write_q) rdata_q <= bus_din;
    end
  end

  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

  // R10: the cycle snapshot is frozen while a cycle runs
  p_snapshot_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> ($stable(cyc_addr_q) && $stable(cyc_bas_q) &&
                           $stable(cyc_write_q) && $stable(cyc_be_q)));

  // R8: completion is a single tick
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R9: a busy block never reports ready on the following tick of a setup
  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETUP) |=> !req_ready);
endmodule

// File: rtl/sramcs_pins.sv
`timescale 1ns/1ps
module sramcs_pins
  import sramcs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_st_e           st_nxt,
  input  logic              cyc_write_nxt,
  input  logic              cyc_bas_nxt,
  input  logic [ADDR_W-1:0] cyc_addr_nxt,
  input  logic [LANES-1:0]  cyc_be_nxt,
  input  logic [DATA_W-1:0] cyc_wdata_nxt,
  output logic              bus_cs_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic [LANES-1:0]  bus_we_n,
  output logic              bus_rdwr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe
);
  logic active, strobe_win;
  logic cs_d, rd_d, rdwr_d, doe_d;

  assign active     = (st_nxt != ST_IDLE);
  assign strobe_win = (st_nxt == ST_STROBE);

  always_comb begin
    cs_d   = active;
    rd_d   = strobe_win & ~cyc_write_nxt;
    rdwr_d = cyc_write_nxt & (cyc_bas_nxt ? strobe_win : active);
    doe_d  = active & cyc_write_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_cs_n   <= 1'b1;
      bus_rd_n   <= 1'b1;
      bus_rdwr_n <= 1'b1;
      bus_doe    <= 1'b0;
      bus_addr   <= '0;
      bus_dout   <= '0;
    end else begin
      bus_cs_n   <= ~cs_d;
      bus_rd_n   <= ~rd_d;
      bus_rdwr_n <= ~rdwr_d;
      bus_doe    <= doe_d;
      if (active)           bus_addr <= cyc_addr_nxt;
      if (doe_d)            bus_dout <= cyc_wdata_nxt;
    end
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic lane_d;
    assign lane_d = cyc_be_nxt[ln] & (cyc_bas_nxt ? active : strobe_win);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_we_n[ln] <= 1'b1;
      else        bus_we_n[ln] <= ~lane_d;
    end
  end

  // R3: strobes never start together with chip select
  p_setup_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> bus_rd_n);

  // R4: chip select survives the end of the strobe
  p_cs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> !bus_cs_n);

  // R4: address is steady across consecutive chip-select ticks
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

  // R5: read strobe only inside chip select and never with data driven
  p_rd_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (!bus_cs_n && !bus_doe));
endmodule

// File: rtl/sramcs_bus_gen.sv
`timescale 1ns/1ps
module sramcs_bus_gen
  import sramcs_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int STROBE_HC = 2,
  localparam int LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_cs_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic [LANES-1:0]  bus_we_n,
  output logic              bus_rdwr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din
);
  logic              rst_n;
  tim_cfg_t          tcfg;
  bus_st_e           st_nxt;
  logic              cyc_write_nxt, cyc_bas_nxt;
  logic [ADDR_W-1:0] cyc_addr_nxt;
  logic [LANES-1:0]  cyc_be_nxt;
  logic [DATA_W-1:0] cyc_wdata_nxt;

  sramcs_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  sramcs_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .tcfg  (tcfg)
  );

  sramcs_seq #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LANES (LANES), .STROBE_HC (STROBE_HC)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .tcfg          (tcfg),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_be        (req_be),
    .req_wdata     (req_wdata),
    .req_ready     (req_ready),
    .bus_din       (bus_din),
    .st_nxt        (st_nxt),
    .cyc_write_nxt (cyc_write_nxt),
    .cyc_bas_nxt   (cyc_bas_nxt),
    .cyc_addr_nxt  (cyc_addr_nxt),
    .cyc_be_nxt    (cyc_be_nxt),
    .cyc_wdata_nxt (cyc_wdata_nxt),
    .rsp_done      (rsp_done),
    .rsp_rdata     (rsp_rdata)
  );

  sramcs_pins #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LANES (LANES)
  ) u_pins (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_nxt        (st_nxt),
    .cyc_write_nxt (cyc_write_nxt),
    .cyc_bas_nxt   (cyc_bas_nxt),
    .cyc_addr_nxt  (cyc_addr_nxt),
    .cyc_be_nxt    (cyc_be_nxt),
    .cyc_wdata_nxt (cyc_wdata_nxt),
    .bus_cs_n      (bus_cs_n),
    .bus_addr      (bus_addr),
    .bus_rd_n      (bus_rd_n),
    .bus_we_n      (bus_we_n),
    .bus_rdwr_n    (bus_rdwr_n),
    .bus_dout      (bus_dout),
    .bus_doe       (bus_doe)
  );

  // R8: completion always coincides with the hold tick (chip select low)
  p_done_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (!bus_cs_n && bus_rd_n));
endmodule

// File: tb/sramcs_bus_gen_bench.sv
`timescale 1ns/1ps
module sramcs_bus_gen_bench;
  localparam int          AW   = 24;
  localparam int          DW   = 32;
  localparam int          LN   = DW / 8;
  localparam int          SHC  = 2;
  localparam logic [31:0] MASK = 32'h0010_1FFF;

  logic          clk = 1'b0;
  logic          arst_n;
  logic          reg_wr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [LN-1:0] req_be;
  logic [DW-1:0] req_wdata;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic          bus_cs_n, bus_rd_n, bus_rdwr_n, bus_doe;
  logic [AW-1:0] bus_addr;
  logic [LN-1:0] bus_we_n;
  logic [DW-1:0] bus_dout, bus_din;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] cur_cfg;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A5A_1234;
  endfunction

  // SRAM model: valid data only while the read strobe is low
  assign bus_din = (!bus_rd_n) ? mem_word(bus_addr) : 32'hDEAD_BEEF;

  sramcs_bus_gen #(.ADDR_W(AW), .DATA_W(DW), .STROBE_HC(SHC)) u_sramcs_bus_gen (
    .clk(clk), .arst_n(arst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
    .bus_we_n(bus_we_n), .bus_rdwr_n(bus_rdwr_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected pin vector {ready, done, cs_n, rd_n, rdwr_n, doe, we_n}
  function automatic logic [5+LN-1:0] exp_pins(input int t, input int l, input bit bas,
                                               input bit wr, input logic [LN-1:0] be);
    int  endt   = l + SHC + 1;
    bit  act    = (t < endt);
    bit  strb   = (t >= l) && (t < l + SHC);
    logic [LN-1:0] we;
    for (int i = 0; i < LN; i++) we[i] = ~(be[i] & (bas ? act : strb));
    return {1'(t == endt), 1'(t == l + SHC), ~act, ~(strb & ~wr),
            ~(wr & (bas ? strb : act)), 1'(act & wr), we};
  endfunction

  task automatic reg_write(input logic [31:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    cur_cfg = v & MASK;
    check(reg_rdata == cur_cfg, "R2 readback", 64'(reg_rdata), 64'(cur_cfg));
  endtask

  // chg < 0: no register write; chg == 0: on the accept edge; chg > 0: at that tick
  task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [LN-1:0] be,
                         input logic [DW-1:0] wd, input bit junk, input int chg,
                         input logic [31:0] new_cfg);
    int  sw   = int'(cur_cfg[12:11]);
    bit  bas  = cur_cfg[20];
    int  l    = 2 * sw + 1;
    int  endt = l + SHC + 1;
    logic [5+LN-1:0] got, exp;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    if (chg == 0) begin reg_wr = 1'b1; reg_wdata = new_cfg; end
    @(negedge clk);
    for (int t = 0; t <= endt; t++) begin
      got = {req_ready, rsp_done, bus_cs_n, bus_rd_n, bus_rdwr_n, bus_doe, bus_we_n};
      exp = exp_pins(t, l, bas, wr, be);
      check(got == exp, "R3 R4 R5 R6 R7 R9 R11 pins", 64'(got), 64'(exp));
      if (t < endt) begin
        check(bus_addr == a, "R4 addr", 64'(bus_addr), 64'(a));
        if (wr) check(bus_dout == wd, "R11 dout", 64'(bus_dout), 64'(wd));
      end
      if (t == l + SHC && !wr)
        check(rsp_rdata == mem_word(a), "R8 rdata", 64'(rsp_rdata), 64'(mem_word(a)));
      if (t == 0) begin
        if (chg == 0) reg_wr = 1'b0;
        if (junk) begin
          req_valid = 1'b1; req_addr = ~a; req_write = ~wr; req_be = ~be; req_wdata = ~wd;
        end else req_valid = 1'b0;
      end
      if (chg > 0 && t == chg) begin reg_wr = 1'b1; reg_wdata = new_cfg; end
      if (chg > 0 && t == chg + 1) reg_wr = 1'b0;
      if (t == endt - 1) req_valid = 1'b0;
      if (t < endt) @(negedge clk);
    end
    if (chg >= 0) begin
      cur_cfg = new_cfg & MASK;
      check(reg_rdata == cur_cfg, "R2 R10 readback", 64'(reg_rdata), 64'(cur_cfg));
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed = $urandom(32'd7219);
    arst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_be = '0; req_wdata = '0;
    cur_cfg = 32'h0000_0500;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(reg_rdata == 32'h0000_0500, "R1 reg reset", 64'(reg_rdata), 64'h500);
    check({req_ready, rsp_done, bus_cs_n, bus_rd_n, bus_rdwr_n, bus_we_n} ==
          {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, {LN{1'b1}}}, "R1 pins reset",
          64'({req_ready, rsp_done, bus_cs_n, bus_rd_n, bus_rdwr_n, bus_we_n}),
          64'({1'b1, 1'b0, 1'b1, 1'b1, 1'b1, {LN{1'b1}}}));

    // default timing before any write (setup field 0)
    run_txn(1'b0, 24'h00_1234, 4'b1111, 32'h0, 1'b0, -1, 32'h0);

    // R2 reserved bits
    reg_write(32'hFFFF_FFFF);
    reg_write(32'h0000_0000);
    reg_write(32'hFFEF_E000);

    // directed: every setup value, both schemes, read and write, lane patterns
    for (int sw = 0; sw < 4; sw++) begin
      for (int bas = 0; bas < 2; bas++) begin
        reg_write((32'(bas) << 20) | (32'(sw) << 11) | 32'h500);
        run_txn(1'b1, 24'hA5_0000 + 24'(sw), 4'b0001 << sw, 32'hC0DE_0000 + 32'(sw),
                1'b0, -1, 32'h0);
        run_txn(1'b0, 24'h3C_0F00 + 24'(bas), 4'b0110 ^ 4'(bas * 9), 32'h0,
                1'b1, -1, 32'h0);
      end
    end

    // R10: register write on the accept edge, then mid-cycle
    reg_write(32'h0000_0000);
    run_txn(1'b1, 24'h00_0F0F, 4'b1111, 32'h1111_2222, 1'b0, 0, 32'h0010_1800);
    run_txn(1'b0, 24'h00_F0F0, 4'b1000, 32'h0, 1'b0, 2, 32'h0000_0800);
    run_txn(1'b1, 24'h12_3456, 4'b0101, 32'h3333_4444, 1'b1, -1, 32'h0);

    // constrained random
    for (int k = 0; k < 60; k++) begin
      int chg = int'($urandom % 4) - 1;
      if (chg > 2) chg = 2;
      run_txn(1'($urandom), AW'($urandom), LN'($urandom), $urandom,
              1'($urandom), chg, $urandom & 32'h0010_1FFF);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule